// File: doc/BRIEF.md
# Floppy Sector Command Builder

This block turns a linear sector request into the nine-byte read or write command frame that a floppy disk controller expects. A request carries a start sector, a sector count, a read/write flag, a drive number and a two-bit media index. The media index picks one of four built-in geometries. The block latches the request and checks the sector range against the capacity of the selected medium. It then splits the start sector into cylinder, head and sector, and streams the frame out one byte at a time over a valid/ready interface.

The data-rate code of the selected medium is driven from the cycle after acceptance. It is therefore stable before the first command byte appears. A request that runs past the end of the medium produces a one-cycle reject pulse and no bytes. A request that completes produces a one-cycle done pulse after its last byte is taken.

Top module: `fdc_cmd_builder`

## Requirements
- R1: The media index selects the geometry below. On `rate_code`, 2'b10 means 250 kb/s and 2'b00 means 500 kb/s. From the cycle after acceptance until the block is ready again, `rate_code` shows the code of the latched medium.

  | Index | Sectors per track | Cylinders | Total sectors | Gap | Rate |
  |-------|-------------------|-----------|---------------|-----|------|
  | 0 | 9 | 80 | 1440 | 0x2A | 250 |
  | 1 | 18 | 80 | 2880 | 0x1B | 500 |
  | 2 | 9 | 40 | 720 | 0x2A | 250 |
  | 3 | 15 | 80 | 2400 | 0x1B | 500 |

- R2: `req_ready` is high only while the block is idle, and never while a command byte is offered. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. All request fields are captured at that edge, so later changes on the request inputs do not alter the frame.
- R3: If start plus count is greater than the total sector count of the medium, the block pulses `reject` for one cycle, two cycles after acceptance. It emits no byte and returns to ready. A sum equal to the total is accepted.
- R4: The cylinder is start / (2 × sectors per track). The remainder of that division, divided by sectors per track, gives the head. The remainder of that second division is the zero-based sector.
- R5: Byte 0 is 0xC6 when `req_write` is 0 (read) and 0xC5 when `req_write` is 1 (write). This is the multi-track bit 0x80, plus the MFM bit 0x40, plus the opcode.
- R6: Byte 1 is (head << 2) | drive. Byte 2 is the cylinder. Byte 3 is the head. Byte 4 is the zero-based sector plus one.
- R7: Byte 5 is 0x02. Byte 6 is the sectors per track. Byte 7 is the gap of the medium. Byte 8 is 0xFF.
- R8: Bytes go out in the order 0 to 8, one per edge with `cmd_valid` and `cmd_ready` both high. The first byte is offered two cycles after acceptance. While `cmd_ready` is low, `cmd_valid` and `cmd_byte` hold.
- R9: `done` pulses for one cycle right after the handshake of byte 8, and `req_ready` is high in that same cycle. `done` and `reject` are never high together.
- R10: During and after reset, `req_ready` is 1, and `cmd_valid`, `done` and `reject` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_start | input | 12 | First logical sector |
| req_count | input | 12 | Number of sectors |
| req_write | input | 1 | 1 = write, 0 = read |
| req_drive | input | 2 | Drive number |
| req_media | input | 2 | Geometry index |
| rate_code | output | 2 | Data-rate code of latched medium |
| cmd_valid | output | 1 | Command byte offered |
| cmd_ready | input | 1 | Consumer takes the byte |
| cmd_byte | output | 8 | Command byte |
| done | output | 1 | Frame complete pulse |
| reject | output | 1 | Range error pulse |

## Verification
A wrong byte index shows up immediately as a misordered or repeated field, or as a frame that is too short or too long. The end-of-frame check on 0xFF and the done pulse expose this by the ninth handshake. A corrupted latch or quotient shows up in bytes 1 to 4 of that same frame, so the bench compares every byte against values it computes itself. A wrong capacity compare shows up two cycles after acceptance, as a reject where bytes were expected or bytes where a reject was expected. The bench therefore exercises sums just below, exactly at and just above the capacity.

// File: rtl/fdc_cmd_pkg.sv
// Package: shared constants, geometry record and state encoding for the
// floppy sector command builder. Assumes four media entries.
package fdc_cmd_pkg;

    parameter int unsigned SECT_W    = 12;  // sector number / count width
    parameter int unsigned BYTE_W    = 8;
    parameter int unsigned MEDIA_W   = 2;
    parameter int unsigned DRIVE_W   = 2;
    parameter int unsigned RATE_W    = 2;
    parameter int unsigned FRAME_LEN = 9;
    parameter int unsigned IDX_W     = $clog2(FRAME_LEN);

    localparam logic [BYTE_W-1:0] OP_READ   = 8'h06;
    localparam logic [BYTE_W-1:0] OP_WRITE  = 8'h05;
    localparam logic [BYTE_W-1:0] BIT_MT    = 8'h80;
    localparam logic [BYTE_W-1:0] BIT_MFM   = 8'h40;
    localparam logic [BYTE_W-1:0] SIZE_512  = 8'h02;
    localparam logic [BYTE_W-1:0] DTL_FILL  = 8'hFF;
    localparam logic [RATE_W-1:0] RATE_250K = 2'b10;
    localparam logic [RATE_W-1:0] RATE_500K = 2'b00;

    typedef struct packed {
        logic [BYTE_W-1:0] spt;    // sectors per track
        logic [SECT_W-1:0] total;  // sectors on the medium
        logic [BYTE_W-1:0] gap;    // gap length
        logic [RATE_W-1:0] rate;   // data-rate code
    } geom_t;

    typedef struct packed {
        logic               wr;
        logic [DRIVE_W-1:0] drive;
        logic [BYTE_W-1:0]  cyl;
        logic [BYTE_W-1:0]  head;
        logic [BYTE_W-1:0]  sec0;  // zero-based sector
        logic [BYTE_W-1:0]  spt;
        logic [BYTE_W-1:0]  gap;
    } frame_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_EMIT  = 2'd2
    } build_st_t;

endpackage

// File: rtl/fdc_geom_rom.sv
// Module: fdc_geom_rom
// Maps a media index to its geometry record. Purely combinational.
// Assumes the index is MEDIA_W = 2 bits, so all four codes are defined.
module fdc_geom_rom
    import fdc_cmd_pkg::*;
(
    input  logic [MEDIA_W-1:0] media,
    output geom_t              geom
);

    // Select the fixed geometry entry for the requested medium.
    always_comb begin
        unique case (media)
            2'd0:    geom = '{spt: 8'd9,  total: 12'd1440, gap: 8'h2A, rate: RATE_250K};
            2'd1:    geom = '{spt: 8'd18, total: 12'd2880, gap: 8'h1B, rate: RATE_500K};
            2'd2:    geom = '{spt: 8'd9,  total: 12'd720,  gap: 8'h2A, rate: RATE_250K};
            default: geom = '{spt: 8'd15, total: 12'd2400, gap: 8'h1B, rate: RATE_500K};
        endcase
    end

endmodule

// File: rtl/fdc_divmod.sv
// Module: fdc_divmod
// Unsigned combinational restoring divider, one stage per dividend bit.
// Assumes den is non-zero; for den = 0 the outputs are meaningless.
module fdc_divmod #(
    parameter int unsigned NUM_W = 12,
    parameter int unsigned DEN_W = 8
) (
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [NUM_W-1:0] quo,
    output logic [DEN_W-1:0] rem
);

    localparam int unsigned EXT_W = DEN_W + 1;

    logic [DEN_W-1:0] part  [NUM_W+1];
    logic [EXT_W-1:0] shft  [NUM_W];
    logic [EXT_W-1:0] diff  [NUM_W];
    logic [EXT_W-1:0] den_x;

    assign den_x   = {1'b0, den};
    assign part[0] = '0;

    // One restoring stage per dividend bit, most significant bit first.
    for (genvar i = 0; i < NUM_W; i++) begin : g_stage
        assign shft[i]            = {part[i], num[NUM_W-1-i]};
        assign diff[i]            = shft[i] - den_x;
        assign quo[NUM_W-1-i]     = (shft[i] >= den_x);
        assign part[i+1]          = (shft[i] >= den_x) ? diff[i][DEN_W-1:0]
                                                       : shft[i][DEN_W-1:0];
    end

    assign rem = part[NUM_W];

endmodule

// File: rtl/fdc_frame_fmt.sv
// Module: fdc_frame_fmt
// Selects one byte of the nine-byte command frame by index.
// Assumes idx stays below FRAME_LEN; other values yield zero.
module fdc_frame_fmt
    import fdc_cmd_pkg::*;
(
    input  frame_t            frm,
    input  logic [IDX_W-1:0]  idx,
    output logic [BYTE_W-1:0] byte_out
);

    logic [BYTE_W-1:0] opcode;
    logic [BYTE_W-1:0] hd_drv;

    // Opcode byte with multi-track and MFM bits set.
    always_comb opcode = BIT_MT | BIT_MFM | (frm.wr ? OP_WRITE : OP_READ);

    // Head placed above the drive number.
    always_comb hd_drv = {frm.head[BYTE_W-3:0], 2'b00} | BYTE_W'(frm.drive);

    // Index-to-field multiplexer.
    always_comb begin
        case (idx)
            4'd0:    byte_out = opcode;
            4'd1:    byte_out = hd_drv;
            4'd2:    byte_out = frm.cyl;
            4'd3:    byte_out = frm.head;
            4'd4:    byte_out = frm.sec0 + 8'd1;
            4'd5:    byte_out = SIZE_512;
            4'd6:    byte_out = frm.spt;
            4'd7:    byte_out = frm.gap;
            4'd8:    byte_out = DTL_FILL;
            default: byte_out = '0;
        endcase
    end

endmodule

// File: rtl/fdc_cmd_builder.sv
// Module: fdc_cmd_builder (top)
// Accepts a linear sector request and checks it against the capacity of the
// chosen medium. It then computes cylinder/head/sector and streams the
// nine-byte command over valid/ready.
// Assumptions: the consumer may stall indefinitely; a new request is taken
// only when the block is idle; the reset is synchronous and active low.
module fdc_cmd_builder
    import fdc_cmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [SECT_W-1:0]  req_start,
    input  logic [SECT_W-1:0]  req_count,
    input  logic               req_write,
    input  logic [DRIVE_W-1:0] req_drive,
    input  logic [MEDIA_W-1:0] req_media,
    output logic [RATE_W-1:0]  rate_code,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [BYTE_W-1:0]  cmd_byte,
    output logic               done,
    output logic               reject
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
    localparam int unsigned      SUM_W    = SECT_W + 1;

    build_st_t          st;
    logic [SECT_W-1:0]  lat_start;
    logic [SECT_W-1:0]  lat_count;
    logic               lat_wr;
    logic [DRIVE_W-1:0] lat_drive;
    logic [MEDIA_W-1:0] lat_media;
    logic [BYTE_W-1:0]  cyl_q;
    logic [BYTE_W-1:0]  head_q;
    logic [BYTE_W-1:0]  sec_q;
    logic [IDX_W-1:0]   idx;
    logic               done_q;
    logic               reject_q;

    geom_t              geom;
    logic [BYTE_W-1:0]  spc;
    logic [SECT_W-1:0]  cyl_full;
    logic [BYTE_W-1:0]  cyl_rem;
    logic [BYTE_W-1:0]  head_c;
    logic [BYTE_W-1:0]  sec_c;
    logic               over_cap;
    logic [SECT_W-1:0]  unused_cyl_hi;
    frame_t             frm;

    fdc_geom_rom u_geom (
        .media (lat_media),
        .geom  (geom)
    );

    // Sectors per cylinder: two heads per cylinder.
    always_comb spc = {geom.spt[BYTE_W-2:0], 1'b0};

    fdc_divmod #(.NUM_W(SECT_W), .DEN_W(BYTE_W)) u_div_cyl (
        .num (lat_start),
        .den (spc),
        .quo (cyl_full),
        .rem (cyl_rem)
    );

    fdc_divmod #(.NUM_W(BYTE_W), .DEN_W(BYTE_W)) u_div_trk (
        .num (cyl_rem),
        .den (geom.spt),
        .quo (head_c),
        .rem (sec_c)
    );

    assign unused_cyl_hi = cyl_full;

    // Range test: start plus count must not pass the medium capacity.
    always_comb over_cap = (SUM_W'(lat_start) + SUM_W'(lat_count)) > SUM_W'(geom.total);

    // Sequencer: latch, check, then emit bytes one per handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            lat_start <= '0;
            lat_count <= '0;
            lat_wr    <= 1'b0;
            lat_drive <= '0;
            lat_media <= '0;
            cyl_q     <= '0;
            head_q    <= '0;
            sec_q     <= '0;
            idx       <= '0;
            done_q    <= 1'b0;
            reject_q  <= 1'b0;
        end else begin
            done_q   <= 1'b0;
            reject_q <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        lat_start <= req_start;
                        lat_count <= req_count;
                        lat_wr    <= req_write;
                        lat_drive <= req_drive;
                        lat_media <= req_media;
                        st        <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (over_cap) begin
                        reject_q <= 1'b1;
                        st       <= ST_IDLE;
                    end else begin
                        cyl_q  <= cyl_full[BYTE_W-1:0];
                        head_q <= head_c;
                        sec_q  <= sec_c;
                        idx    <= '0;
                        st     <= ST_EMIT;
                    end
                end
                ST_EMIT: begin
                    if (cmd_ready) begin
                        if (idx == LAST_IDX) begin
                            done_q <= 1'b1;
                            st     <= ST_IDLE;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Gather latched and computed fields into one frame record.
    always_comb begin
        frm.wr    = lat_wr;
        frm.drive = lat_drive;
        frm.cyl   = cyl_q;
        frm.head  = head_q;
        frm.sec0  = sec_q;
        frm.spt   = geom.spt;
        frm.gap   = geom.gap;
    end

    fdc_frame_fmt u_fmt (
        .frm      (frm),
        .idx      (idx),
        .byte_out (cmd_byte)
    );

    assign req_ready = (st == ST_IDLE);
    assign cmd_valid = (st == ST_EMIT);
    assign rate_code = geom.rate;
    assign done      = done_q;
    assign reject    = reject_q;

endmodule

// File: rtl/fdc_cmd_builder_chk.sv
// Module: fdc_cmd_builder_chk
// Protocol checker bound to fdc_cmd_builder. It tracks the byte position by
// counting handshakes and checks the ordering and handshake rules.
module fdc_cmd_builder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [7:0] cmd_byte,
    input logic       done,
    input logic       reject
);

    logic [3:0] hs_cnt;

    // Count accepted bytes within the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hs_cnt <= '0;
        else if (cmd_valid && cmd_ready)
            hs_cnt <= (hs_cnt == 4'd8) ? 4'd0 : hs_cnt + 4'd1;
    end

    a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_byte)));

    a_r9_done_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(cmd_valid && cmd_ready));

    a_r9_done_xor_reject: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && reject));

    a_r3_reject_silent: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> !cmd_valid);

    a_r2_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !cmd_valid);

    a_r7_last_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && hs_cnt == 4'd8) |-> (cmd_byte == 8'hFF));

    a_r5_opcode_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && hs_cnt == 4'd0) |-> (cmd_byte[7:6] == 2'b11));

endmodule

bind fdc_cmd_builder fdc_cmd_builder_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_byte  (cmd_byte),
    .done      (done),
    .reject    (reject)
);

// File: tb/test_fdc_cmd_builder.sv
// Directed bench for fdc_cmd_builder: one task per scenario.
module test_fdc_cmd_builder;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [11:0] req_start = '0;
    logic [11:0] req_count = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_drive = '0;
    logic [1:0]  req_media = '0;
    logic [1:0]  rate_code;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [7:0]  cmd_byte;
    logic        done;
    logic        reject;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    fdc_cmd_builder i_fdc_cmd_builder (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_start (req_start), .req_count (req_count),
        .req_write (req_write), .req_drive (req_drive), .req_media (req_media),
        .rate_code (rate_code),
        .cmd_valid (cmd_valid), .cmd_ready (cmd_ready), .cmd_byte (cmd_byte),
        .done (done), .reject (reject)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                chk(0, "watchdog", cycles, WATCHDOG);
                summary();
            end
        end
    end

    function automatic int spt_of(input int m);
        case (m) 0: return 9; 1: return 18; 2: return 9; default: return 15; endcase
    endfunction
    function automatic int tot_of(input int m);
        case (m) 0: return 1440; 1: return 2880; 2: return 720; default: return 2400; endcase
    endfunction
    function automatic int gap_of(input int m);
        return (m == 1 || m == 3) ? 8'h1B : 8'h2A;
    endfunction
    function automatic int rate_of(input int m);
        return (m == 1 || m == 3) ? 0 : 2;
    endfunction

    // R10: state during and after reset.
    task automatic t_reset();
        @(negedge clk); #1;
        chk(req_ready == 1'b1, "R10 ready in reset", int'(req_ready), 1);
        chk(cmd_valid == 1'b0, "R10 valid in reset", int'(cmd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(done == 1'b0 && reject == 1'b0, "R10 pulses idle", int'({done, reject}), 0);
        chk(req_ready == 1'b1, "R10 ready after reset", int'(req_ready), 1);
    endtask

    // Offer a request, hold it for the accepting edge, then scramble inputs (R2).
    task automatic offer(input int st, input int cnt, input bit wr, input int drv, input int m);
        @(negedge clk);
        req_start = 12'(st); req_count = 12'(cnt); req_write = wr;
        req_drive = 2'(drv); req_media = 2'(m); req_valid = 1'b1;
        #1;
        chk(req_ready == 1'b1, "R2 ready before request", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        req_start = 12'hABC; req_count = 12'h7FF; req_write = ~wr;
        req_drive = ~2'(drv); req_media = ~2'(m);
        #1;
        chk(req_ready == 1'b0, "R2 busy after accept", int'(req_ready), 0);
        chk(rate_code == 2'(rate_of(m)), "R1 rate code", int'(rate_code), rate_of(m));
    endtask

    // Request that must be refused (R3).
    task automatic t_reject(input int st, input int cnt, input int m);
        offer(st, cnt, 1'b0, 0, m);
        @(negedge clk); #1;
        chk(reject == 1'b1, "R3 reject pulse", int'(reject), 1);
        chk(cmd_valid == 1'b0, "R3 no byte", int'(cmd_valid), 0);
        @(negedge clk); #1;
        chk(reject == 1'b0, "R3 pulse width", int'(reject), 0);
        chk(req_ready == 1'b1 && cmd_valid == 1'b0, "R3 back to ready",
            int'({req_ready, cmd_valid}), 2);
    endtask

    // Accepted request: collect nine bytes with optional stalls (R4-R9).
    task automatic t_frame(input int st, input int cnt, input bit wr, input int drv,
                           input int m, input bit stall);
        int exp [9];
        int spt, cyl, r, head, sec, n, k;
        bit prev_stall;
        logic [7:0] prev_byte;
        spt  = spt_of(m);
        cyl  = st / (2 * spt);
        r    = st % (2 * spt);
        head = r / spt;
        sec  = r % spt;
        exp[0] = wr ? 8'hC5 : 8'hC6;
        exp[1] = (head << 2) | drv;
        exp[2] = cyl;
        exp[3] = head;
        exp[4] = sec + 1;
        exp[5] = 8'h02;
        exp[6] = spt;
        exp[7] = gap_of(m);
        exp[8] = 8'hFF;
        chk(st + cnt <= tot_of(m), "R3 bench range", st + cnt, tot_of(m));
        offer(st, cnt, wr, drv, m);
        n = 0; k = 0; prev_stall = 0; prev_byte = '0;
        while (n < 9 && k < 200) begin
            @(negedge clk);
            cmd_ready = !(stall && (k % 3 == 1));
            #1;
            if (prev_stall)
                chk(cmd_valid && cmd_byte == prev_byte, "R8 hold on stall",
                    int'(cmd_byte), int'(prev_byte));
            if (k == 0)
                chk(cmd_valid == 1'b1, "R8 first byte timing", int'(cmd_valid), 1);
            prev_stall = cmd_valid && !cmd_ready;
            prev_byte  = cmd_byte;
            if (cmd_valid && cmd_ready) begin
                if (n == 0)      chk(cmd_byte == 8'(exp[n]), "R5 opcode", int'(cmd_byte), exp[n]);
                else if (n <= 4) chk(cmd_byte == 8'(exp[n]), "R4 R6 address byte", int'(cmd_byte), exp[n]);
                else             chk(cmd_byte == 8'(exp[n]), "R7 fixed byte", int'(cmd_byte), exp[n]);
                n++;
            end
            k++;
        end
        chk(n == 9, "R8 byte count", n, 9);
        @(negedge clk);
        cmd_ready = 1'b0;
        #1;
        chk(done == 1'b1, "R9 done pulse", int'(done), 1);
        chk(req_ready == 1'b1 && cmd_valid == 1'b0, "R9 ready with done",
            int'({req_ready, cmd_valid}), 2);
        @(negedge clk); #1;
        chk(done == 1'b0, "R9 done width", int'(done), 0);
    endtask

    initial begin
        t_reset();
        t_frame(0,    1,  1'b0, 0, 0, 1'b0);  // first sector, 250 kb/s medium
        t_frame(37,   5,  1'b1, 3, 1, 1'b1);  // write, drive 3, stalls
        t_frame(2879, 1,  1'b1, 1, 1, 1'b0);  // last sector, head 1
        t_frame(1234, 10, 1'b0, 2, 3, 1'b1);  // 15-sector medium, stalls
        t_frame(400,  3,  1'b0, 1, 2, 1'b0);  // 40-cylinder medium
        t_reject(719, 2, 2);                  // one past capacity
        t_frame(2390, 10, 1'b0, 0, 3, 1'b0);  // sum equals capacity: accepted
        t_reject(2390, 11, 3);                // one past capacity
        t_frame(17,   1,  1'b1, 2, 0, 1'b1);  // head 1 on first cylinder
        summary();
    end

endmodule